// File: doc/BRIEF.md
# PHY Control-Register Write Master

This block writes internal registers of a serial-link PHY through a narrow, strobe-driven control-register port. One register write is three separately acknowledged phases on a 20-bit command word. The first captures the register address. The second captures the data value. The third commits the write while the data value is still on the bus. After each phase the master lowers its strobe and waits for the acknowledge to fall before it starts the next phase. Every wait, whether for the rise or for the fall of the acknowledge, has its own bounded window.

A caller starts a single write with a one-cycle `start` pulse and the address and data inputs. A `tune_start` pulse instead runs a built-in program of two preset override writes: register 0x15 receives 0xA409, and then register 0x12 receives 0xA000. The 0xA409 value packs a loss-of-signal bias of 5 in bits 15:13, an override enable in bit 10 and a detect level of 9 in bits 4:0. The 0xA000 value packs a transmit boost level of 5 in bits 15:13. The block shows `busy` for the whole transaction. It ends with either a one-cycle `done` or a one-cycle `err`, together with a code that names the phase that failed.

Internally a sequencer (states SQ_IDLE, SQ_ISSUE, SQ_WAIT, SQ_DONE, SQ_FAIL) feeds one write at a time to a phase engine (states PH_IDLE, PH_STROBE, PH_RELEASE). The engine's transitions are:
- PH_IDLE to PH_STROBE on a go request.
- PH_STROBE to PH_RELEASE when the acknowledge is high.
- PH_RELEASE to the next PH_STROBE when the acknowledge is low, or back to PH_IDLE with a finish flag after the third phase.
- PH_STROBE or PH_RELEASE to PH_IDLE with a fail flag when the window expires.

The sequencer's transitions are:
- SQ_IDLE to SQ_ISSUE on an accepted request.
- SQ_ISSUE to SQ_WAIT as the go request is issued.
- SQ_WAIT to SQ_ISSUE when a tune write other than the last one finishes.
- SQ_WAIT to SQ_DONE when the last write finishes, or to SQ_FAIL when the engine fails.
- SQ_DONE and SQ_FAIL back to SQ_IDLE after one cycle.

A window counter restarts on every engine state change.

Top module: `phy_cr_writer`

## Requirements
- R1: After reset `cr_cmd` is 0, `busy`, `done` and `err` are 0, and `err_code` is 0.
- R2: A write presents three strobes in a fixed order, and each one shows once.
  - First, bit 0 (capture address) is set with the address in bits 17:2.
  - Second, bit 1 (capture data) is set with the data value in bits 17:2.
  - Third, bit 19 (write) is set with the data value in bits 17:2.
  - At most one strobe bit is set at a time, and bit 18 (read) is never set.
- R3: A phase's strobe stays high until `cr_ack` is 1 and then drops. The next strobe never rises while `cr_ack` is still 1.
- R4: A wait for `cr_ack` to rise or to fall gives up after LIMIT = CLK_MHZ*TIMEOUT_US cycles. On a rise timeout the strobe is high for exactly LIMIT cycles. On any timeout `cr_cmd` returns to 0, no further phase is issued, and `err` pulses.
- R5: `err_code` names the failing phase: 1 for capture address, 2 for capture data, 3 for write. It reads 0 after a successful transaction.
- R6: On success `done` pulses for exactly one cycle. `busy` is 1 from the cycle after an accepted request through the `done` or `err` cycle, and it is 0 in the cycle after that.
- R7: `tune_start` writes register 0x15 with 0xA409 (LOS bias 5 in bits 15:13, enable in bit 10, level 9 in bits 4:0). It then writes register 0x12 with 0xA000 (boost 5 in bits 15:13). A single `done` follows the second write.
- R8: If a tune write fails, the remaining tune write is skipped, `err` pulses with that write's phase code, and `done` does not pulse.
- R9: `start` and `tune_start` are ignored while `busy` is 1. When both arrive in the same idle cycle, `start` wins.
- R10: `err_code` keeps its value after `err` until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse: run one write of `wr_data` to `wr_addr` |
| wr_addr | input | 16 | Register address for a single write |
| wr_data | input | 16 | Data value for a single write |
| tune_start | input | 1 | Pulse: run the two-write tune program |
| cr_cmd | output | 20 | Command word to the PHY port (strobes and 16-bit field) |
| cr_ack | input | 1 | Acknowledge bit from the PHY status word |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse: transaction completed |
| err | output | 1 | One-cycle pulse: transaction aborted on timeout |
| err_code | output | 2 | Failing phase: 1 address, 2 data, 3 write; 0 when no error |

## Verification
A phase engine stuck in PH_STROBE or PH_RELEASE shows at the ports as a strobe that never drops, or as a missing next strobe. The window counter then turns either of these into an `err` after LIMIT cycles, so a hang cannot go unnoticed. A phase counter that skips or repeats a step shows up at once as a wrong strobe order or a wrong field in the captured command log. A window counter that fails to restart shows as a strobe-high count different from LIMIT. A sequencer that loses its tune index shows as a missing or repeated 0x12 write, or as an early `done`, before the second write's first strobe.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;

    localparam int FIELD_W = 16;
    localparam int CMD_W   = FIELD_W + 4;

    localparam int STB_ADDR  = 0;
    localparam int STB_DATA  = 1;
    localparam int FIELD_LO  = 2;
    localparam int FIELD_HI  = FIELD_LO + FIELD_W - 1;
    localparam int STB_READ  = FIELD_HI + 1;
    localparam int STB_WRITE = FIELD_HI + 2;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_STROBE,
        PH_RELEASE
    } ph_state_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT,
        SQ_DONE,
        SQ_FAIL
    } sq_state_t;

    localparam logic [FIELD_W-1:0] LOS_REG   = 16'h0015;
    localparam logic [FIELD_W-1:0] BOOST_REG = 16'h0012;

    function automatic logic [FIELD_W-1:0] tune_addr(input logic idx);
        return idx ? BOOST_REG : LOS_REG;
    endfunction

    function automatic logic [FIELD_W-1:0] tune_data(input logic idx);
        logic [FIELD_W-1:0] v;
        v = '0;
        if (idx) begin
            v[15:13] = 3'd5;
        end else begin
            v[15:13] = 3'd5;
            v[10]    = 1'b1;
            v[4:0]   = 5'd9;
        end
        return v;
    endfunction

endpackage

// File: rtl/phy_cr_window.sv
module phy_cr_window #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expired
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    assign expired = (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r4_window_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !expired);

endmodule

// File: rtl/phy_cr_phase_engine.sv
module phy_cr_phase_engine
    import phy_cr_pkg::*;
#(
    parameter int LIMIT = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [FIELD_W-1:0] addr,
    input  logic [FIELD_W-1:0] data,
    input  logic               cr_ack,
    output logic [CMD_W-1:0]   cr_cmd,
    output logic               fin,
    output logic               fail,
    output logic [1:0]         fail_code
);
    ph_state_t  state, state_nxt;
    logic [1:0] phase;
    logic       expired;
    logic       win_clear;

    assign win_clear = (state == PH_IDLE) || (state_nxt != state);

    phy_cr_window #(.LIMIT(LIMIT)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (win_clear),
        .expired (expired)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            PH_IDLE:    if (go) state_nxt = PH_STROBE;
            PH_STROBE:  if (cr_ack) state_nxt = PH_RELEASE;
                        else if (expired) state_nxt = PH_IDLE;
            PH_RELEASE: if (!cr_ack) state_nxt = (phase == 2'd2) ? PH_IDLE : PH_STROBE;
                        else if (expired) state_nxt = PH_IDLE;
            default:    state_nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_IDLE;
            phase <= 2'd0;
        end else begin
            state <= state_nxt;
            if (state == PH_IDLE) begin
                phase <= 2'd0;
            end else if (state == PH_RELEASE && state_nxt == PH_STROBE) begin
                phase <= phase + 2'd1;
            end
        end
    end

    always_comb begin
        cr_cmd    = '0;
        fin       = 1'b0;
        fail      = 1'b0;
        fail_code = phase + 2'd1;
        unique case (state)
            PH_IDLE: ;
            PH_STROBE: begin
                cr_cmd[FIELD_HI:FIELD_LO] = (phase == 2'd0) ? addr : data;
                cr_cmd[STB_ADDR]  = (phase == 2'd0);
                cr_cmd[STB_DATA]  = (phase == 2'd1);
                cr_cmd[STB_WRITE] = (phase == 2'd2);
                fail = !cr_ack && expired;
            end
            PH_RELEASE: begin
                cr_cmd[FIELD_HI:FIELD_LO] = (phase == 2'd0) ? addr : data;
                fin  = !cr_ack && (phase == 2'd2);
                fail = cr_ack && expired;
            end
            default: ;
        endcase
    end

    logic strobe_any;
    assign strobe_any = cr_cmd[STB_ADDR] | cr_cmd[STB_DATA] | cr_cmd[STB_WRITE];

    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cr_cmd[STB_WRITE], cr_cmd[STB_READ], cr_cmd[STB_DATA], cr_cmd[STB_ADDR]}));

    a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_STROBE && !cr_ack && !expired) |=> (state == PH_STROBE && $stable(cr_cmd)));

    a_r3_rise_after_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_RELEASE && state_nxt == PH_STROBE) |-> !cr_ack);

    a_r4_abort_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_STROBE && expired && !cr_ack) |=> (state == PH_IDLE && !strobe_any));

endmodule

// File: rtl/phy_cr_sequencer.sv
module phy_cr_sequencer
    import phy_cr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FIELD_W-1:0] wr_addr,
    input  logic [FIELD_W-1:0] wr_data,
    input  logic               tune_start,
    input  logic               fin,
    input  logic               fail,
    input  logic [1:0]         fail_code,
    output logic               go,
    output logic [FIELD_W-1:0] cur_addr,
    output logic [FIELD_W-1:0] cur_data,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [1:0]         err_code
);
    sq_state_t state, state_nxt;
    logic      is_tune;
    logic      idx;

    always_comb begin
        state_nxt = state;
        unique case (state)
            SQ_IDLE:  if (start || tune_start) state_nxt = SQ_ISSUE;
            SQ_ISSUE: state_nxt = SQ_WAIT;
            SQ_WAIT:  if (fail) state_nxt = SQ_FAIL;
                      else if (fin) state_nxt = (is_tune && !idx) ? SQ_ISSUE : SQ_DONE;
            SQ_DONE:  state_nxt = SQ_IDLE;
            SQ_FAIL:  state_nxt = SQ_IDLE;
            default:  state_nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            is_tune  <= 1'b0;
            idx      <= 1'b0;
            cur_addr <= '0;
            cur_data <= '0;
            err_code <= 2'd0;
        end else begin
            state <= state_nxt;
            unique case (state)
                SQ_IDLE: begin
                    if (start) begin
                        is_tune  <= 1'b0;
                        idx      <= 1'b0;
                        cur_addr <= wr_addr;
                        cur_data <= wr_data;
                        err_code <= 2'd0;
                    end else if (tune_start) begin
                        is_tune  <= 1'b1;
                        idx      <= 1'b0;
                        cur_addr <= tune_addr(1'b0);
                        cur_data <= tune_data(1'b0);
                        err_code <= 2'd0;
                    end
                end
                SQ_WAIT: begin
                    if (fail) begin
                        err_code <= fail_code;
                    end else if (fin && is_tune && !idx) begin
                        idx      <= 1'b1;
                        cur_addr <= tune_addr(1'b1);
                        cur_data <= tune_data(1'b1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        go   = (state == SQ_ISSUE);
        busy = (state != SQ_IDLE);
        done = (state == SQ_DONE);
        err  = (state == SQ_FAIL);
    end

    a_r6_done_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    a_r6_busy_ends_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done || err));

    a_r8_fail_stops_program: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_WAIT && fail) |=> (err && !go));

    a_r10_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SQ_IDLE && state != SQ_WAIT) |=> $stable(err_code));

endmodule

// File: rtl/phy_cr_writer.sv
module phy_cr_writer
    import phy_cr_pkg::*;
#(
    parameter int CLK_MHZ    = 100,
    parameter int TIMEOUT_US = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FIELD_W-1:0] wr_addr,
    input  logic [FIELD_W-1:0] wr_data,
    input  logic               tune_start,
    output logic [CMD_W-1:0]   cr_cmd,
    input  logic               cr_ack,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [1:0]         err_code
);
    localparam int LIMIT = CLK_MHZ * TIMEOUT_US;

    logic               go, fin, fail;
    logic [1:0]         fail_code;
    logic [FIELD_W-1:0] cur_addr, cur_data;

    phy_cr_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .tune_start (tune_start),
        .fin        (fin),
        .fail       (fail),
        .fail_code  (fail_code),
        .go         (go),
        .cur_addr   (cur_addr),
        .cur_data   (cur_data),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .err_code   (err_code)
    );

    phy_cr_phase_engine #(.LIMIT(LIMIT)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .addr      (cur_addr),
        .data      (cur_data),
        .cr_ack    (cr_ack),
        .cr_cmd    (cr_cmd),
        .fin       (fin),
        .fail      (fail),
        .fail_code (fail_code)
    );

endmodule

// File: tb/test_phy_cr_writer.sv
module test_phy_cr_writer;
    localparam int LIMIT = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        tune_start = 1'b0;
    logic [19:0] cr_cmd;
    logic        cr_ack = 1'b0;
    logic        busy, done, err;
    logic [1:0]  err_code;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    phy_cr_writer #(.CLK_MHZ(100), .TIMEOUT_US(1)) i_phy_cr_writer (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_addr(wr_addr),
        .wr_data(wr_data), .tune_start(tune_start), .cr_cmd(cr_cmd),
        .cr_ack(cr_ack), .busy(busy), .done(done), .err(err), .err_code(err_code)
    );

    // PHY model and strobe log
    logic [19:0] log_cmd [0:15];
    int log_n = 0;
    int hi_cnt = 0;
    int cur = -1;
    int stuck_at = -1;
    int sticky_at = -1;
    int ack_dly = 2;
    int acnt = 0;
    logic prev_stb = 1'b0;
    logic viol = 1'b0;
    logic rd_seen = 1'b0;
    logic multi_seen = 1'b0;

    wire stb = cr_cmd[0] | cr_cmd[1] | cr_cmd[19];

    always @(negedge clk) begin
        cycles++;
        if (cr_cmd[18]) rd_seen = 1'b1;
        if ((cr_cmd[0] + cr_cmd[1] + cr_cmd[19]) > 1) multi_seen = 1'b1;
        if (stb && !prev_stb) begin
            if (cr_ack) viol = 1'b1;
            if (log_n < 16) log_cmd[log_n] = cr_cmd;
            cur = log_n;
            log_n++;
            hi_cnt = 0;
        end
        if (!stb && prev_stb && !cr_ack && cur != stuck_at) viol = 1'b1;
        if (stb) hi_cnt++;
        if (stb && !cr_ack) begin
            if (cur != stuck_at) begin
                acnt++;
                if (acnt >= ack_dly) begin cr_ack = 1'b1; acnt = 0; end
            end
        end else if (!stb && cr_ack) begin
            if (cur != sticky_at) begin
                acnt++;
                if (acnt >= ack_dly) begin cr_ack = 1'b0; acnt = 0; end
            end
        end else begin
            acnt = 0;
        end
        prev_stb = stb;
    end

    initial begin
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] ecmd(input int ph, input logic [15:0] v);
        logic [19:0] c;
        c = '0;
        c[17:2] = v;
        if (ph == 0) c[0] = 1'b1;
        else if (ph == 1) c[1] = 1'b1;
        else c[19] = 1'b1;
        return c;
    endfunction

    task automatic clear_log(input int stk, input int sty);
        log_n = 0; cur = -1; viol = 1'b0; rd_seen = 1'b0; multi_seen = 1'b0;
        stuck_at = stk; sticky_at = sty;
    endtask

    // wait for done/err; returns counts of pulses and busy-low violations
    task automatic wait_end(output int n_done, output int n_err, output logic busy_ok);
        int k;
        logic fin_seen;
        n_done = 0; n_err = 0; busy_ok = 1'b1; fin_seen = 1'b0;
        for (k = 0; k < 3000 && !fin_seen; k++) begin
            @(negedge clk);
            if (!busy) busy_ok = 1'b0;
            if (done) n_done++;
            if (err) n_err++;
            if (done || err) fin_seen = 1'b1;
        end
        @(negedge clk);
        if (done) n_done++;
        if (err) n_err++;
        if (busy) busy_ok = 1'b0;
    endtask

    task automatic pulse(input logic s, input logic t, input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        start = s; tune_start = t; wr_addr = a; wr_data = d;
        @(negedge clk);
        start = 1'b0; tune_start = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 cmd", cr_cmd, 0);
        check("R1 busy/done/err", {busy, done, err}, 0);
        check("R1 err_code", err_code, 0);
    endtask

    task automatic t_single(input logic [15:0] a, input logic [15:0] d, input int dly);
        int nd, ne; logic bok;
        ack_dly = dly;
        clear_log(-1, -1);
        pulse(1'b1, 1'b0, a, d);
        check("R6 busy after start", busy, 1);
        wait_end(nd, ne, bok);
        check("R6 one done", nd, 1);
        check("R6 no err", ne, 0);
        check("R6 busy span", bok, 1);
        check("R2 strobe count", log_n, 3);
        check("R2 addr phase", log_cmd[0], ecmd(0, a));
        check("R2 data phase", log_cmd[1], ecmd(1, d));
        check("R2 write phase", log_cmd[2], ecmd(2, d));
        check("R2 no read/one strobe", {rd_seen, multi_seen}, 0);
        check("R3 handshake order", viol, 0);
        check("R5 code after success", err_code, 0);
        check("R1 cmd idle after", cr_cmd, 0);
    endtask

    task automatic t_ignore_busy();
        int nd, ne; logic bok;
        ack_dly = 3;
        clear_log(-1, -1);
        pulse(1'b1, 1'b0, 16'h0101, 16'h2020);
        repeat (4) @(negedge clk);
        pulse(1'b1, 1'b0, 16'h0F0F, 16'h3333);
        pulse(1'b0, 1'b1, 16'h0, 16'h0);
        wait_end(nd, ne, bok);
        check("R9 ignored while busy count", log_n, 3);
        check("R9 ignored while busy addr", log_cmd[0], ecmd(0, 16'h0101));
        check("R9 ignored while busy data", log_cmd[2], ecmd(2, 16'h2020));
        repeat (12) @(negedge clk);
        check("R9 no later transaction", log_n, 3);
    endtask

    task automatic t_priority();
        int nd, ne; logic bok;
        ack_dly = 1;
        clear_log(-1, -1);
        pulse(1'b1, 1'b1, 16'h0042, 16'h5A5A);
        wait_end(nd, ne, bok);
        check("R9 start wins count", log_n, 3);
        check("R9 start wins addr", log_cmd[0], ecmd(0, 16'h0042));
        check("R9 start wins done", nd, 1);
    endtask

    task automatic t_timeout_rise();
        int nd, ne; logic bok;
        ack_dly = 2;
        clear_log(1, -1);
        pulse(1'b1, 1'b0, 16'h0007, 16'hBEEF);
        wait_end(nd, ne, bok);
        check("R4 err pulse", ne, 1);
        check("R4 no done", nd, 0);
        check("R4 strobe high LIMIT cycles", hi_cnt, LIMIT);
        check("R4 no further phase", log_n, 2);
        check("R4 cmd cleared", cr_cmd, 0);
        check("R5 data phase code", err_code, 2);
        repeat (5) @(negedge clk);
        check("R10 code held", err_code, 2);
        stuck_at = -1;
    endtask

    task automatic t_timeout_fall();
        int nd, ne; logic bok;
        ack_dly = 2;
        clear_log(-1, 0);
        pulse(1'b1, 1'b0, 16'h0003, 16'h1111);
        wait_end(nd, ne, bok);
        check("R4 fall timeout err", ne, 1);
        check("R4 fall timeout no next", log_n, 1);
        check("R5 addr phase code", err_code, 1);
        sticky_at = -1;
        repeat (6) @(negedge clk);
        check("R10 code held after ack drop", err_code, 1);
    endtask

    task automatic t_tune();
        int nd, ne; logic bok;
        ack_dly = 2;
        clear_log(-1, -1);
        pulse(1'b0, 1'b1, 16'h0, 16'h0);
        wait_end(nd, ne, bok);
        check("R7 six strobes", log_n, 6);
        check("R7 los addr", log_cmd[0], ecmd(0, 16'h0015));
        check("R7 los data", log_cmd[1], ecmd(1, 16'hA409));
        check("R7 los write", log_cmd[2], ecmd(2, 16'hA409));
        check("R7 boost addr", log_cmd[3], ecmd(0, 16'h0012));
        check("R7 boost data", log_cmd[4], ecmd(1, 16'hA000));
        check("R7 boost write", log_cmd[5], ecmd(2, 16'hA000));
        check("R7 single done", nd, 1);
        check("R7 busy across both", bok, 1);
        check("R10 code cleared by new request", err_code, 0);
    endtask

    task automatic t_tune_fail();
        int nd, ne; logic bok;
        ack_dly = 2;
        clear_log(2, -1);
        pulse(1'b0, 1'b1, 16'h0, 16'h0);
        wait_end(nd, ne, bok);
        repeat (10) @(negedge clk);
        check("R8 second write skipped", log_n, 3);
        check("R8 err pulse", ne, 1);
        check("R8 no done", nd, 0);
        check("R8 write phase code", err_code, 3);
        stuck_at = -1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_single(16'h0015, 16'hA409, 2);
        t_single(16'hFFFF, 16'h0000, 1);
        t_single(16'h8001, 16'h7FFE, 5);
        t_ignore_busy();
        t_priority();
        t_timeout_rise();
        t_timeout_fall();
        t_tune();
        t_tune_fail();
        t_single(16'h0030, 16'hC0DE, 3);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule